// File: doc/BRIEF.md
# Majority-Vote Digital Input Filter

This block cleans up a single-bit comparator output before trip and status logic use it. The raw level first passes through a two-flop synchroniser. A programmable prescaler then sets how often that level is sampled, and the newest samples are kept in a window whose length is programmable from 1 to 32.

The filtered output changes state only after enough samples in the window agree on the new level. The number of samples needed is a programmable threshold. A second output carries a registered status copy of the filtered level.

An initialisation input fills the whole window with the current synchronised level and moves the output to that level at once. This avoids a long settling period after the filter is configured.

Top module: `glitch_vote_filter`

## Requirements
- R1: During and right after synchronous active-low reset, `filt_o` and `status_o` are 0, every window sample is 0 and the prescaler count is 0.
- R2: `din_i` reaches the sample window through two flops. With `prescale_i`=0, window length 1 and threshold 1, a change on `din_i` before clock edge k shows on `filt_o` after edge k+3.
- R3: A sample is shifted into the window only on a prescaler strobe. With `prescale_i`=N, a strobe occurs every N+1 clocks. The first strobe comes N clocks after reset is released, and the count restarts after each strobe.
- R4: The window length is `win_sel_i`+1, giving 1 to 32. Only the newest `win_sel_i`+1 samples are counted, and older samples in the register have no effect.
- R5: With a valid configuration, `filt_o` becomes 1 on the edge after the count of ones in the window is at least `thresh_i`.
- R6: With a valid configuration, `filt_o` becomes 0 on the edge after the count of zeros in the window is at least `thresh_i`.
- R7: With a valid configuration where neither count reaches `thresh_i`, `filt_o` keeps its value.
- R8: If 2×`thresh_i` ≤ window length (this includes `thresh_i`=0), the configuration is invalid. `filt_o` then keeps its value, whatever the samples are.
- R9: While `init_i` is 1, every window sample is loaded with the synchronised level, and `filt_o` takes that level on the next edge. `init_i` has priority over voting and over sample shifting.
- R10: `status_o` equals the value `filt_o` had one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din_i | input | 1 | Raw comparator level (asynchronous) |
| init_i | input | 1 | Preload the window and output from the current level |
| prescale_i | input | PRE_W (16) | Strobe period minus one |
| win_sel_i | input | SEL_W (5) | Window length minus one |
| thresh_i | input | CNT_W (6) | Number of agreeing samples needed to change the output |
| filt_o | output | 1 | Filtered level |
| status_o | output | 1 | Registered status copy of the filtered level |

## Verification
The filter is driven with isolated one-clock pulses, bursts shorter than the threshold, and steady level changes. Single pulses must leave the output unchanged, while steady changes must pass after exactly the expected number of samples. Pseudo-random chatter is run across several prescale values, window lengths up to 32, and thresholds at both the majority boundary and the window length. This separates correct window masking and strobe timing from off-by-one errors. Invalid thresholds and initialisation pulses at both levels confirm that the output holds or preloads as required.

// File: rtl/gvf_pkg.sv
// Shared types for the majority-vote input filter.
// Assumes nothing beyond IEEE 1800-2017 synthesizable types.
package gvf_pkg;
    // Outcome of one vote evaluation over the sample window.
    typedef enum logic [1:0] {
        VOTE_HOLD = 2'd0,
        VOTE_HIGH = 2'd1,
        VOTE_LOW  = 2'd2
    } vote_e;
endpackage

// File: rtl/gvf_sync.sv
// Multi-flop synchroniser for one asynchronous level.
// Assumes STAGES >= 2. Its output lags the input by STAGES clocks.
module gvf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gvf_strobe.sv
// Sample-rate prescaler: it raises strobe_o for one clock out of every limit_i+1.
// Assumes limit_i may change at any time. A count above the new limit
// strobes at once and restarts from zero.
module gvf_strobe #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] limit_i,
    output logic             strobe_o
);
    logic [PRE_W-1:0] cnt_q;

    assign strobe_o = (cnt_q >= limit_i);

    // Count clocks, and restart the count on every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (strobe_o) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/gvf_window.sv
// Sample window: a shift register of DEPTH samples, newest in bit 0.
// It reports the number of ones among the newest sel_i+1 samples and that length.
// Assumes DEPTH <= 2**SEL_W and CNT_W bits can hold DEPTH.
module gvf_window #(
    parameter int DEPTH = 32,
    parameter int SEL_W = 5,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic             bit_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] ones_o,
    output logic [CNT_W-1:0] len_o
);
    logic [DEPTH-1:0] smp_q;
    logic [DEPTH-1:0] mask;
    logic [DEPTH-1:0] kept;

    // Preload all samples, or shift in the newest one on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       smp_q <= '0;
        else if (load_i)  smp_q <= {DEPTH{bit_i}};
        else if (shift_i) smp_q <= {smp_q[DEPTH-2:0], bit_i};
    end

    // Per-position enable: keep only positions inside the selected length.
    for (genvar g = 0; g < DEPTH; g++) begin : g_mask
        assign mask[g] = (SEL_W'(g) <= sel_i);
    end

    assign kept  = smp_q & mask;
    assign len_o = CNT_W'(sel_i) + CNT_W'(1);

    // Population count of the kept samples.
    always_comb begin
        ones_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            ones_o = ones_o + CNT_W'(kept[i]);
        end
    end
endmodule

// File: rtl/gvf_decide.sv
// Vote and output register: it applies the threshold rule to the window count
// and holds the filtered level and its status copy.
// Assumes ones_i <= len_i. A threshold of half the length or less is invalid and holds.
module gvf_decide #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             lvl_i,
    input  logic [CNT_W-1:0] ones_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic             filt_o,
    output logic             status_o
);
    import gvf_pkg::*;

    logic [CNT_W-1:0] zeros;
    logic [CNT_W:0]   thr_x2;
    logic             cfg_ok;
    vote_e            vote;

    assign zeros  = len_i - ones_i;
    assign thr_x2 = {thresh_i, 1'b0};
    assign cfg_ok = (thr_x2 > {1'b0, len_i});

    // Choose a new level, or hold, from the window counts.
    always_comb begin
        vote = VOTE_HOLD;
        if (cfg_ok) begin
            if (ones_i >= thresh_i)     vote = VOTE_HIGH;
            else if (zeros >= thresh_i) vote = VOTE_LOW;
        end
    end

    // Register the filtered level, and copy the previous level into status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_o   <= 1'b0;
            status_o <= 1'b0;
        end else begin
            status_o <= filt_o;
            if (init_i) begin
                filt_o <= lvl_i;
            end else begin
                case (vote)
                    VOTE_HIGH: filt_o <= 1'b1;
                    VOTE_LOW:  filt_o <= 1'b0;
                    default:   filt_o <= filt_o;
                endcase
            end
        end
    end
endmodule

// File: rtl/glitch_vote_filter.sv
// Top of the majority-vote input filter: synchroniser, prescaler, sample window
// and vote register. Assumes WIN_MAX >= 2 and that all configuration inputs
// are synchronous to clk.
module glitch_vote_filter #(
    parameter int WIN_MAX = 32,
    parameter int PRE_W   = 16,
    parameter int SYNC_N  = 2,
    localparam int SEL_W  = $clog2(WIN_MAX),
    localparam int CNT_W  = $clog2(WIN_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din_i,
    input  logic             init_i,
    input  logic [PRE_W-1:0] prescale_i,
    input  logic [SEL_W-1:0] win_sel_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic             filt_o,
    output logic             status_o
);
    logic             sync_lvl;
    logic             smp_stb;
    logic [CNT_W-1:0] ones_cnt;
    logic [CNT_W-1:0] win_len;

    gvf_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (din_i),
        .q_o   (sync_lvl)
    );

    gvf_strobe #(.PRE_W(PRE_W)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .limit_i  (prescale_i),
        .strobe_o (smp_stb)
    );

    gvf_window #(.DEPTH(WIN_MAX), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (init_i),
        .shift_i (smp_stb),
        .bit_i   (sync_lvl),
        .sel_i   (win_sel_i),
        .ones_o  (ones_cnt),
        .len_o   (win_len)
    );

    gvf_decide #(.CNT_W(CNT_W)) u_decide (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_i   (init_i),
        .lvl_i    (sync_lvl),
        .ones_i   (ones_cnt),
        .len_i    (win_len),
        .thresh_i (thresh_i),
        .filt_o   (filt_o),
        .status_o (status_o)
    );
endmodule

// File: rtl/glitch_vote_filter_chk.sv
// Property checker for the majority-vote filter, bound into every instance.
module glitch_vote_filter_chk #(
    parameter int PRE_W = 16,
    parameter int SEL_W = 5,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_i,
    input logic [PRE_W-1:0] prescale_i,
    input logic [SEL_W-1:0] win_sel_i,
    input logic [CNT_W-1:0] thresh_i,
    input logic             filt_o,
    input logic             status_o,
    input logic             sync_lvl,
    input logic             smp_stb,
    input logic [CNT_W-1:0] ones_cnt
);
    logic [CNT_W:0] len_x;
    logic [CNT_W:0] zeros_x;
    logic [CNT_W:0] thr_x;

    assign len_x   = (CNT_W+1)'(win_sel_i) + 1'b1;
    assign zeros_x = len_x - (CNT_W+1)'(ones_cnt);
    assign thr_x   = (CNT_W+1)'(thresh_i);

    assert_status_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_o == $past(filt_o)));

    assert_init_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (filt_o == $past(sync_lvl)));

    assert_bad_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && ((thr_x << 1) <= len_x)) |=> $stable(filt_o));

    assert_no_early_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !filt_o && ((CNT_W+1)'(ones_cnt) < thr_x)) |=> !filt_o);

    assert_no_early_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && filt_o && (zeros_x < thr_x)) |=> filt_o);

    assert_strobe_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && (prescale_i != '0)) |=> (!smp_stb || (prescale_i == '0)));

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (CNT_W+1)'(ones_cnt) <= len_x);
endmodule

bind glitch_vote_filter glitch_vote_filter_chk #(
    .PRE_W(PRE_W), .SEL_W(SEL_W), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (init_i),
    .prescale_i (prescale_i),
    .win_sel_i  (win_sel_i),
    .thresh_i   (thresh_i),
    .filt_o     (filt_o),
    .status_o   (status_o),
    .sync_lvl   (sync_lvl),
    .smp_stb    (smp_stb),
    .ones_cnt   (ones_cnt)
);

// File: tb/glitch_vote_filter_tb_top.sv
// Bench for the majority-vote filter: a behavioural reference model compared
// on every clock, plus directed checks on latency, glitches and configuration edges.
module glitch_vote_filter_tb_top;
    localparam int PRE_W = 16;
    localparam int SEL_W = 5;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             din = 1'b0;
    logic             init = 1'b0;
    logic [PRE_W-1:0] prescale = '0;
    logic [SEL_W-1:0] win_sel = '0;
    logic [CNT_W-1:0] thresh = '0;
    logic             filt;
    logic             status;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";

    // Model state
    bit m_s1, m_s2, m_filt, m_stat;
    int m_cnt;
    bit hist[$];
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    glitch_vote_filter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .din_i      (din),
        .init_i     (init),
        .prescale_i (prescale),
        .win_sel_i  (win_sel),
        .thresh_i   (thresh),
        .filt_o     (filt),
        .status_o   (status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp_v, cycles);
        end
    endtask

    // Reference model: advance one clock from the values present at the edge.
    always @(posedge clk) begin
        int len, ones, zeros, cnt_next;
        bit nf, stb;
        cycles++;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_filt = 0; m_stat = 0; m_cnt = 0;
            hist.delete();
            for (int k = 0; k < 32; k++) hist.push_back(1'b0);
        end else begin
            len = int'(win_sel) + 1;
            ones = 0;
            for (int k = 0; k < len; k++) ones += int'(hist[k]);
            zeros = len - ones;
            nf = m_filt;
            if (init) nf = m_s2;
            else if (2 * int'(thresh) > len) begin
                if (ones >= int'(thresh)) nf = 1'b1;
                else if (zeros >= int'(thresh)) nf = 1'b0;
            end
            stb = (m_cnt >= int'(prescale));
            if (init) begin
                for (int k = 0; k < 32; k++) hist[k] = m_s2;
            end else if (stb) begin
                hist.push_front(m_s2);
                void'(hist.pop_back());
            end
            cnt_next = stb ? 0 : m_cnt + 1;
            m_cnt = cnt_next;
            m_stat = m_filt;
            m_filt = nf;
            m_s2 = m_s1;
            m_s1 = din;
        end
    end

    // Compare on every falling edge against the model.
    always @(negedge clk) begin
        if (cmp_on) begin
            check(filt == m_filt, cur_req, int'(filt), int'(m_filt));
            check(status == m_stat, "R10", int'(status), int'(m_stat));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int pre, input int wsel, input int th);
        prescale = PRE_W'(pre);
        win_sel  = SEL_W'(wsel);
        thresh   = CNT_W'(th);
    endtask

    task automatic chatter(input int n, input int bias);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (int'(lfsr[3:0]) < bias) din = ~din;
            tick(1);
        end
    endtask

    task automatic do_init(input bit lvl);
        din = lvl;
        tick(3);
        init = 1'b1;
        tick(1);
        init = 1'b0;
    endtask

    // Watchdog
    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: outputs held low through reset even with input high
        din = 1'b1;
        tick(4);
        check(filt == 1'b0, "R1", int'(filt), 0);
        check(status == 1'b0, "R1", int'(status), 0);
        din = 1'b0;
        tick(3);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        tick(2);
        check(filt == 1'b0, "R1", int'(filt), 0);

        // R2: latency of three edges then output change
        cur_req = "R2";
        cfg(0, 0, 1);
        tick(4);
        din = 1'b1;
        tick(3);
        check(filt == 1'b0, "R2", int'(filt), 0);
        tick(1);
        check(filt == 1'b1, "R2", int'(filt), 1);
        tick(1);
        check(status == 1'b1, "R10", int'(status), 1);
        din = 1'b0;
        tick(6);
        check(filt == 1'b0, "R2", int'(filt), 0);

        // R5/R6/R7: window 5, threshold 3, single glitches are rejected
        cur_req = "R7";
        cfg(0, 4, 3);
        tick(8);
        din = 1'b1; tick(1); din = 1'b0; tick(8);
        check(filt == 1'b0, "R7", int'(filt), 0);
        din = 1'b1; tick(2); din = 1'b0; tick(8);
        check(filt == 1'b0, "R7", int'(filt), 0);
        cur_req = "R5";
        din = 1'b1; tick(10);
        check(filt == 1'b1, "R5", int'(filt), 1);
        cur_req = "R6";
        din = 1'b0; tick(1); din = 1'b1; tick(6);
        check(filt == 1'b1, "R6", int'(filt), 1);
        din = 1'b0; tick(10);
        check(filt == 1'b0, "R6", int'(filt), 0);

        // R3: prescaled sampling with chatter
        cur_req = "R3";
        cfg(3, 6, 5);
        chatter(400, 4);
        din = 1'b1; tick(60);
        check(filt == 1'b1, "R3", int'(filt), 1);
        cfg(1, 2, 2);
        chatter(300, 8);

        // R4: full window, threshold at the majority edge and at full length
        cur_req = "R4";
        cfg(0, 31, 17);
        chatter(500, 6);
        cfg(0, 31, 32);
        chatter(300, 1);
        din = 1'b0; tick(40);
        check(filt == 1'b0, "R4", int'(filt), 0);
        din = 1'b1; tick(33);
        check(filt == 1'b0, "R4", int'(filt), 0);
        tick(3);
        check(filt == 1'b1, "R4", int'(filt), 1);
        // Shrinking the window: older samples outside it are ignored
        cfg(0, 1, 2);
        din = 1'b0; tick(6);
        check(filt == 1'b0, "R4", int'(filt), 0);

        // R8: invalid thresholds hold the output
        cur_req = "R8";
        cfg(0, 7, 4);
        din = 1'b1; tick(20);
        check(filt == 1'b0, "R8", int'(filt), 0);
        cfg(0, 0, 0);
        tick(10);
        check(filt == 1'b0, "R8", int'(filt), 0);
        chatter(100, 8);

        // R9: initialisation at both levels
        cur_req = "R9";
        cfg(5, 9, 8);
        do_init(1'b1);
        check(filt == 1'b1, "R9", int'(filt), 1);
        din = 1'b0; tick(12);
        check(filt == 1'b1, "R9", int'(filt), 1);
        do_init(1'b0);
        check(filt == 1'b0, "R9", int'(filt), 0);
        chatter(300, 5);

        cmp_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule